// File: doc/BRIEF.md
# Removable Media Presence Monitor

This block sits beside a storage bridge's command engine and tells it whether the single removable medium (always treated as the master device) is present. It also tells it which sense code to give in answer to a request-sense command. A raw presence pin is synchronised and debounced. The pin's active level is then chosen by a polarity bit. A small state machine turns the filtered level into a present flag and a sense code pair (additional sense code and its qualifier) with a valid flag.

While the medium is missing, the block reports the "no medium" code (0x3A/0x00). When the medium returns, the block raises the "medium changed" code (0x28/0x00). That code is held until the bridge pulses `sense_taken`, which it does once the code has been sent to the host. It is a one-shot event and does not follow the pin. If the feature-enable bit is clear, the block reports the medium as present and raises no code.

States:
- `MW_OFF`: feature disabled.
- `MW_PRESENT`: medium in, no code.
- `MW_ABSENT`: medium out, no-medium code.
- `MW_CHANGED`: medium back, changed code pending.

Transitions:
- Any state to `MW_OFF` when enable is clear.
- `MW_OFF` to `MW_PRESENT` or `MW_ABSENT` when enabled, chosen by the filtered level.
- `MW_PRESENT` to `MW_ABSENT` on removal.
- `MW_ABSENT` to `MW_CHANGED` on insertion.
- `MW_CHANGED` to `MW_ABSENT` on removal. Removal wins over `sense_taken`.
- `MW_CHANGED` to `MW_PRESENT` on `sense_taken`.

Top module: `media_watch`

## Requirements
- R1: While `cfg_enable` is 0, from the next cycle on: `media_present`=1, `sense_valid`=0, `sense_asc`=0x00 and `sense_ascq`=0x00, whatever the pin does.
- R2: With `cfg_active_high`=1, a high pin means the medium is present. With `cfg_active_high`=0, a low pin means present.
- R3: A change of the pin's meaning takes effect only after it has been seen for DEBOUNCE_CYCLES consecutive synchronised samples. A pulse shorter than that has no effect. An edge on the pin shows at the outputs after SYNC_STAGES+DEBOUNCE_CYCLES+1 clock edges.
- R4: In the absent state: `media_present`=0, `sense_valid`=1, `sense_asc`=0x3A, `sense_ascq`=0x00.
- R5: When the medium is detected again after an absence, the outputs are `media_present`=1, `sense_valid`=1, `sense_asc`=0x28, `sense_ascq`=0x00.
- R6: The 0x28 code stays until a cycle with `sense_taken`=1. After that cycle the outputs are `sense_valid`=0 and 0x00/0x00, with `media_present`=1.
- R7: `sense_taken` has no effect while the medium is absent. The 0x3A code remains.
- R8: If removal is filtered in the same cycle as `sense_taken` while 0x28 is pending, the block goes to the absent state (0x3A).
- R9: After reset the outputs are `media_present`=1, `sense_valid`=0, 0x00/0x00. The filtered level starts as present, and the synchroniser stages start at 0.
- R10: Enabling the feature while the filtered level says absent gives 0x3A, never 0x28.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_enable | input | 1 | Feature enable |
| cfg_active_high | input | 1 | 1: pin high means present; 0: pin low means present |
| pin_raw | input | 1 | Asynchronous presence pin |
| sense_taken | input | 1 | One-cycle strobe: sense data was sent to the host |
| media_present | output | 1 | Medium present flag |
| sense_valid | output | 1 | A sense code is raised |
| sense_asc | output | 8 | Additional sense code |
| sense_ascq | output | 8 | Additional sense code qualifier |

## Verification
The hardest case to reach is R8, where removal and the host's consumption of the pending 0x28 code land on the same clock edge. The bench counts the exact filter latency from the pin edge and places the one-cycle `sense_taken` strobe on that edge. The boundary of the debounce window is reached in a similar way: one glitch is held for one sample fewer than the limit, and the bench then checks the output on the edges just before and just at the full latency.

// File: rtl/media_watch_pkg.sv
package media_watch_pkg;
    typedef enum logic [1:0] {
        MW_OFF,
        MW_PRESENT,
        MW_ABSENT,
        MW_CHANGED
    } mw_state_e;

    localparam logic [7:0] ASC_NONE          = 8'h00;
    localparam logic [7:0] ASC_NO_MEDIUM     = 8'h3A;
    localparam logic [7:0] ASC_MEDIUM_CHANGE = 8'h28;
    localparam logic [7:0] ASCQ_ZERO         = 8'h00;
endpackage

// File: rtl/media_sync.sv
module media_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= 1'b0;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/media_debounce.sv
module media_debounce #(
    parameter int HOLD_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic flt
);
    localparam int CW = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
    localparam logic [CW-1:0] LIMIT = CW'(HOLD_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flt <= 1'b1;
            cnt <= '0;
        end else if (lvl == flt) begin
            cnt <= '0;
        end else if (cnt == LIMIT) begin
            flt <= lvl;
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/media_sense_fsm.sv
module media_sense_fsm
    import media_watch_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       present_flt,
    input  logic       sense_taken,
    output logic       media_present,
    output logic       sense_valid,
    output logic [7:0] sense_asc,
    output logic [7:0] sense_ascq
);
    mw_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        if (!enable) begin
            state_nx = MW_OFF;
        end else begin
            unique case (state)
                MW_OFF:     state_nx = present_flt ? MW_PRESENT : MW_ABSENT;
                MW_PRESENT: if (!present_flt) state_nx = MW_ABSENT;
                MW_ABSENT:  if (present_flt)  state_nx = MW_CHANGED;
                MW_CHANGED: begin
                    if (!present_flt)     state_nx = MW_ABSENT;
                    else if (sense_taken) state_nx = MW_PRESENT;
                end
                default:    state_nx = MW_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= MW_OFF;
        else        state <= state_nx;
    end

    always_comb begin
        media_present = 1'b1;
        sense_valid   = 1'b0;
        sense_asc     = ASC_NONE;
        sense_ascq    = ASCQ_ZERO;
        unique case (state)
            MW_OFF, MW_PRESENT: ;
            MW_ABSENT: begin
                media_present = 1'b0;
                sense_valid   = 1'b1;
                sense_asc     = ASC_NO_MEDIUM;
            end
            MW_CHANGED: begin
                sense_valid = 1'b1;
                sense_asc   = ASC_MEDIUM_CHANGE;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/media_watch.sv
module media_watch #(
    parameter int SYNC_STAGES     = 2,
    parameter int DEBOUNCE_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_enable,
    input  logic       cfg_active_high,
    input  logic       pin_raw,
    input  logic       sense_taken,
    output logic       media_present,
    output logic       sense_valid,
    output logic [7:0] sense_asc,
    output logic [7:0] sense_ascq
);
    logic pin_sync;
    logic lvl_present;
    logic flt_present;

    media_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst_n (rst_n),
        .d (pin_raw),
        .q (pin_sync)
    );

    assign lvl_present = cfg_active_high ? pin_sync : ~pin_sync;

    media_debounce #(.HOLD_CYCLES(DEBOUNCE_CYCLES)) u_deb (
        .clk (clk),
        .rst_n (rst_n),
        .lvl (lvl_present),
        .flt (flt_present)
    );

    media_sense_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable        (cfg_enable),
        .present_flt   (flt_present),
        .sense_taken   (sense_taken),
        .media_present (media_present),
        .sense_valid   (sense_valid),
        .sense_asc     (sense_asc),
        .sense_ascq    (sense_ascq)
    );
endmodule

// File: rtl/media_watch_chk.sv
module media_watch_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_enable,
    input logic       sense_taken,
    input logic       lvl_present,
    input logic       flt_present,
    input logic       media_present,
    input logic       sense_valid,
    input logic [7:0] sense_asc,
    input logic [7:0] sense_ascq
);
    assert_off_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> (media_present && !sense_valid && sense_asc == 8'h00));

    assert_filter_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(flt_present) |-> ($past(lvl_present) == flt_present));

    assert_absent_outputs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sense_asc == 8'h3A) |-> (!media_present && sense_valid && sense_ascq == 8'h00));

    assert_change_after_absent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sense_asc == 8'h28 && !$past(sense_asc == 8'h28)) |-> ($past(sense_asc) == 8'h3A));

    assert_change_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sense_asc == 8'h28 && !sense_taken && flt_present && cfg_enable) |=> (sense_asc == 8'h28));

    assert_change_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sense_asc == 8'h28 && sense_taken && flt_present && cfg_enable) |=> (!sense_valid && media_present));

    assert_absent_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sense_asc == 8'h3A && !flt_present && cfg_enable) |=> (sense_asc == 8'h3A));

    assert_removal_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sense_asc == 8'h28 && sense_taken && !flt_present && cfg_enable) |=> (sense_asc == 8'h3A));
endmodule

bind media_watch media_watch_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_enable    (cfg_enable),
    .sense_taken   (sense_taken),
    .lvl_present   (lvl_present),
    .flt_present   (flt_present),
    .media_present (media_present),
    .sense_valid   (sense_valid),
    .sense_asc     (sense_asc),
    .sense_ascq    (sense_ascq)
);

// File: tb/media_watch_bench.sv
`timescale 1ns/1ps
module media_watch_bench;
    localparam int SYNC = 2;
    localparam int DEB  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_enable = 1'b0;
    logic cfg_active_high = 1'b1;
    logic pin_raw = 1'b0;
    logic sense_taken = 1'b0;
    logic       media_present, sense_valid;
    logic [7:0] sense_asc, sense_ascq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    media_watch #(.SYNC_STAGES(SYNC), .DEBOUNCE_CYCLES(DEB)) u_media_watch (
        .clk (clk), .rst_n (rst_n), .cfg_enable (cfg_enable),
        .cfg_active_high (cfg_active_high), .pin_raw (pin_raw),
        .sense_taken (sense_taken), .media_present (media_present),
        .sense_valid (sense_valid), .sense_asc (sense_asc), .sense_ascq (sense_ascq)
    );

    // Behavioural reference: pin history queue, run-length counter, mode number
    bit pin_hist[$] = '{0, 0};
    int run_len = 0;
    bit m_flt = 1'b1;
    int mode = 0; // 0 off, 1 present, 2 absent, 3 changed

    always @(posedge clk) begin
        bit seen;
        bit lvl;
        int nmode;
        if (!rst_n) begin
            pin_hist = '{0, 0};
            run_len = 0;
            m_flt = 1'b1;
            mode = 0;
        end else begin
            seen = pin_hist[0];
            lvl = cfg_active_high ? seen : !seen;
            nmode = mode;
            if (!cfg_enable) nmode = 0;
            else if (mode == 0) nmode = m_flt ? 1 : 2;
            else if (!m_flt) nmode = 2;
            else if (mode == 2) nmode = 3;
            else if (mode == 3 && sense_taken) nmode = 1;
            mode = nmode;
            if (lvl == m_flt) run_len = 0;
            else begin
                run_len++;
                if (run_len == DEB) begin
                    m_flt = lvl;
                    run_len = 0;
                end
            end
            void'(pin_hist.pop_front());
            pin_hist.push_back(pin_raw);
        end
    end

    function automatic logic [17:0] exp_of(int m);
        case (m)
            2:       return {1'b0, 1'b1, 8'h3A, 8'h00};
            3:       return {1'b1, 1'b1, 8'h28, 8'h00};
            default: return {1'b1, 1'b0, 8'h00, 8'h00};
        endcase
    endfunction

    function automatic logic [17:0] act();
        return {media_present, sense_valid, sense_asc, sense_ascq};
    endfunction

    task automatic check(string tag, logic [17:0] e);
        checks++;
        if (act() !== e) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act(), e, $time);
        end
    endtask

    // Comparison with the model every cycle
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (act() !== exp_of(mode)) begin
                errors++;
                $display("FAIL R2/R3/R4/R5 model: actual=%h expected=%h at %0t",
                         act(), exp_of(mode), $time);
            end
        end
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    localparam logic [17:0] QUIET   = {1'b1, 1'b0, 8'h00, 8'h00};
    localparam logic [17:0] NOMED   = {1'b0, 1'b1, 8'h3A, 8'h00};
    localparam logic [17:0] CHANGED = {1'b1, 1'b1, 8'h28, 8'h00};

    initial begin
        step(3);
        @(negedge clk); check("R9 reset", QUIET);
        step(1); rst_n = 1'b1;
        step(20);
        @(negedge clk); check("R1 disabled with pin absent", QUIET);
        step(1); cfg_enable = 1'b1;
        step(1);
        @(negedge clk); check("R10 enable while absent", NOMED);
        sense_taken = 1'b1; step(1); sense_taken = 1'b0;
        @(negedge clk); check("R7 taken ignored when absent", NOMED);
        pin_raw = 1'b1; step(DEB - 1); pin_raw = 1'b0;
        step(12);
        @(negedge clk); check("R3 short glitch ignored", NOMED);
        pin_raw = 1'b1;
        repeat (SYNC + DEB) @(posedge clk);
        @(negedge clk); check("R3 one edge before latency", NOMED);
        @(posedge clk);
        @(negedge clk); check("R5 medium changed", CHANGED);
        step(10);
        @(negedge clk); check("R6 changed held", CHANGED);
        sense_taken = 1'b1; step(1); sense_taken = 1'b0;
        @(negedge clk); check("R6 cleared by taken", QUIET);
        pin_raw = 1'b0; step(12);
        @(negedge clk); check("R4 removal", NOMED);
        pin_raw = 1'b1; step(12);
        @(negedge clk); check("R5 second insertion", CHANGED);
        pin_raw = 1'b0;
        step(SYNC + DEB);
        sense_taken = 1'b1; step(1); sense_taken = 1'b0;
        @(negedge clk); check("R8 removal beats taken", NOMED);
        cfg_active_high = 1'b0; step(12);
        @(negedge clk); check("R2 low pin present", CHANGED);
        pin_raw = 1'b1; step(12);
        @(negedge clk); check("R2 high pin absent", NOMED);
        cfg_enable = 1'b0; step(1);
        @(negedge clk); check("R1 disable quiets", QUIET);
        pin_raw = 1'b0; step(12);
        @(negedge clk); check("R1 pin ignored while disabled", QUIET);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule